// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block is the status side of a NOR-style flash model. A command decoder tells it when a command sequence has finished (a one-cycle start pulse taken at the first rising write strobe that ends the sequence), whether that command is a program or an erase, and which sector a program targets. An algorithm model pulses a done input when the embedded operation ends, and a level input asks for erase suspend. The block also takes a per-sector erase-select vector and a per-sector protect vector.

From these it tracks the operation state and drives an active-low open-drain ready/busy enable. On every read strobe it updates a status byte: bit 6 is the busy/suspend toggle and bit 2 is the sector-select toggle. A valid flag tells the read mux whether to present this byte or array data. A program aimed at a protected sector, or an erase whose selected sectors are all protected, opens a short toggle window. The window length is a clock-cycle count derived from the clock frequency. When it ends, the device returns to its previous mode.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rb_low_o` is 0, `rd_stat_o` is 8'h00 and `rd_stat_vld_o` is 0.
- R2: `rb_low_o` is 1 while a program or erase runs, during a program issued in erase suspend, and during a protect window. It is 0 when idle and while erase is suspended.
- R3: While a program or erase runs, each read strobe at any sector inverts bit 6 of `rd_stat_o`. Only bits 6 and 2 of the status byte may be nonzero.
- R4: Once an operation completes, reads leave bit 6 unchanged and return `rd_stat_vld_o` = 0. Without a read strobe, `rd_stat_o` and `rd_stat_vld_o` hold.
- R5: In erase suspend, reads leave bit 6 unchanged. When `suspend_i` drops, the erase resumes and bit 6 toggles again.
- R6: A program to an unprotected sector in erase suspend sets `rb_low_o` and toggles bit 6. Its done pulse returns the block to erase suspend with `rb_low_o` = 0.
- R7: Bit 2 inverts on a read whose sector is in the effective erase set (erase-select and not protected, captured at erase start), both while erasing and while suspended. Reads of other sectors leave bit 2 unchanged.
- R8: A program start to a protected sector makes the block busy for exactly WIN_CYC = CLK_MHZ*WIN_NS/1000 cycles, with bit 6 toggling on reads. It then returns to the mode it came from.
- R9: An erase start whose effective erase set is empty opens the same window and then returns to idle. When only some selected sectors are protected, the protected ones are left out of the effective set.
- R10: While busy, start pulses are ignored. In erase suspend, an erase start is ignored.
- R11: `rd_stat_vld_o` is 1 for a read taken in any non-idle state. The exception is erase suspend, where a read of a sector outside the effective set gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Command sequence completed (one-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase command, 0 = program command |
| op_sector_i | input | SECT_W | Target sector of a program |
| alg_done_i | input | 1 | Embedded algorithm finished |
| suspend_i | input | 1 | Erase suspend request (level) |
| erase_sel_i | input | N_SECT | Sectors selected for erase |
| protect_i | input | N_SECT | Protected sectors |
| rd_i | input | 1 | Read strobe |
| rd_sector_i | input | SECT_W | Sector of the read address |
| rb_low_o | output | 1 | Open-drain pull-down enable (1 = busy) |
| rd_stat_o | output | 8 | Status byte of the last read |
| rd_stat_vld_o | output | 1 | Last read presents status, not array data |

## Verification
The bench reads in erase suspend both inside and outside the effective set. A design that kept bit 6 toggling there, or that dropped bit 2 toggling when suspended, gets caught on those reads. It measures the protect window against WIN_CYC to catch off-by-one counters, and it issues an erase whose selected sectors are all protected to show the device never starts a real erase. It mixes protected and unprotected selections to catch a design that toggles bit 2 for skipped sectors. It also sends start pulses while busy and in suspend, to catch a state machine that restarts or leaves suspend.

// File: rtl/flash_st_pkg.sv
package flash_st_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_ESUSP = 3'd3,
    ST_SPROG = 3'd4,
    ST_PWIN  = 3'd5
  } st_e;

  localparam int unsigned STAT_W   = 8;
  localparam int unsigned TGL6_BIT = 6;
  localparam int unsigned TGL2_BIT = 2;
endpackage

// File: rtl/flash_st_win_cnt.sv
module flash_st_win_cnt #(
  parameter int unsigned WIN_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (en_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/flash_st_fsm.sv
module flash_st_fsm
  import flash_st_pkg::*;
#(
  parameter int unsigned N_SECT = 8,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [SECT_W-1:0] op_sector_i,
  input  logic              alg_done_i,
  input  logic              suspend_i,
  input  logic [N_SECT-1:0] erase_sel_i,
  input  logic [N_SECT-1:0] protect_i,
  input  logic              win_last_i,
  output st_e               st_o,
  output logic [N_SECT-1:0] mask_o,
  output logic              win_load_o,
  output logic              busy_o
);
  st_e              st_q, st_d;
  st_e              ret_q, ret_d;
  logic [N_SECT-1:0] mask_q, mask_d;
  logic [N_SECT-1:0] eff_sel;
  logic              prot_hit;

  assign eff_sel = erase_sel_i & ~protect_i;

  always_comb begin
    prot_hit = 1'b0;
    for (int i = 0; i < N_SECT; i++) begin
      if (op_sector_i == SECT_W'(i)) prot_hit = protect_i[i];
    end
  end

  always_comb begin
    st_d       = st_q;
    ret_d      = ret_q;
    mask_d     = mask_q;
    win_load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (op_start_i) begin
          if (!op_erase_i) begin
            if (prot_hit) begin
              st_d       = ST_PWIN;
              ret_d      = ST_IDLE;
              win_load_o = 1'b1;
            end else begin
              st_d = ST_PROG;
            end
          end else if (eff_sel == '0) begin
            st_d       = ST_PWIN;
            ret_d      = ST_IDLE;
            win_load_o = 1'b1;
          end else begin
            st_d   = ST_ERASE;
            mask_d = eff_sel;
          end
        end
      end
      ST_PROG: begin
        if (alg_done_i) st_d = ST_IDLE;
      end
      ST_ERASE: begin
        if (alg_done_i) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (suspend_i) begin
          st_d = ST_ESUSP;
        end
      end
      ST_ESUSP: begin
        if (op_start_i && !op_erase_i) begin
          if (prot_hit) begin
            st_d       = ST_PWIN;
            ret_d      = ST_ESUSP;
            win_load_o = 1'b1;
          end else begin
            st_d = ST_SPROG;
          end
        end else if (!suspend_i) begin
          st_d = ST_ERASE;
        end
      end
      ST_SPROG: begin
        if (alg_done_i) st_d = ST_ESUSP;
      end
      ST_PWIN: begin
        if (win_last_i) st_d = ret_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      mask_q <= mask_d;
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
  assign busy_o = (st_q == ST_PROG) || (st_q == ST_ERASE) ||
                  (st_q == ST_SPROG) || (st_q == ST_PWIN);
endmodule

// File: rtl/flash_st_toggle.sv
module flash_st_toggle
  import flash_st_pkg::*;
#(
  parameter int unsigned N_SECT = 8,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  st_e               st_i,
  input  logic [N_SECT-1:0] mask_i,
  output logic [STAT_W-1:0] rd_stat_o,
  output logic              rd_stat_vld_o
);
  logic t6_q, t2_q, vld_q;
  logic sel_hit, tog6, vld_d;

  always_comb begin
    sel_hit = 1'b0;
    for (int i = 0; i < N_SECT; i++) begin
      if (rd_sector_i == SECT_W'(i)) sel_hit = mask_i[i];
    end
  end

  assign tog6  = (st_i == ST_PROG) || (st_i == ST_ERASE) ||
                 (st_i == ST_SPROG) || (st_i == ST_PWIN);
  assign vld_d = (st_i != ST_IDLE) && !((st_i == ST_ESUSP) && !sel_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q  <= 1'b0;
      t2_q  <= 1'b0;
      vld_q <= 1'b0;
    end else if (rd_i) begin
      t6_q  <= t6_q ^ tog6;
      t2_q  <= t2_q ^ sel_hit;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    rd_stat_o           = '0;
    rd_stat_o[TGL6_BIT] = t6_q;
    rd_stat_o[TGL2_BIT] = t2_q;
  end
  assign rd_stat_vld_o = vld_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_st_pkg::*;
#(
  parameter int unsigned N_SECT  = 8,
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned WIN_NS  = 2000,
  localparam int unsigned SECT_W = (N_SECT < 2) ? 1 : $clog2(N_SECT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [SECT_W-1:0] op_sector_i,
  input  logic              alg_done_i,
  input  logic              suspend_i,
  input  logic [N_SECT-1:0] erase_sel_i,
  input  logic [N_SECT-1:0] protect_i,
  input  logic              rd_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  output logic              rb_low_o,
  output logic [7:0]        rd_stat_o,
  output logic              rd_stat_vld_o
);
  localparam int unsigned WIN_RAW = CLK_MHZ * WIN_NS / 1000;
  localparam int unsigned WIN_CYC = (WIN_RAW < 1) ? 1 : WIN_RAW;

  st_e              st_q;
  logic [N_SECT-1:0] erase_mask;
  logic              win_load, win_last;

  flash_st_fsm #(.N_SECT(N_SECT), .SECT_W(SECT_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_start_i  (op_start_i),
    .op_erase_i  (op_erase_i),
    .op_sector_i (op_sector_i),
    .alg_done_i  (alg_done_i),
    .suspend_i   (suspend_i),
    .erase_sel_i (erase_sel_i),
    .protect_i   (protect_i),
    .win_last_i  (win_last),
    .st_o        (st_q),
    .mask_o      (erase_mask),
    .win_load_o  (win_load),
    .busy_o      (rb_low_o)
  );

  flash_st_win_cnt #(.WIN_CYC(WIN_CYC)) i_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (win_load),
    .en_i   (st_q == ST_PWIN),
    .last_o (win_last)
  );

  flash_st_toggle #(.N_SECT(N_SECT), .SECT_W(SECT_W)) i_tgl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (rd_i),
    .rd_sector_i   (rd_sector_i),
    .st_i          (st_q),
    .mask_i        (erase_mask),
    .rd_stat_o     (rd_stat_o),
    .rd_stat_vld_o (rd_stat_vld_o)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_st_pkg::*;
#(
  parameter int unsigned N_SECT  = 8,
  parameter int unsigned SECT_W  = 3,
  parameter int unsigned WIN_CYC = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alg_done_i,
  input logic              rd_i,
  input logic [SECT_W-1:0] rd_sector_i,
  input logic              rb_low_o,
  input logic [7:0]        rd_stat_o,
  input logic              rd_stat_vld_o,
  input st_e               st_i,
  input logic [N_SECT-1:0] mask_i
);
  logic [31:0] win_run_q;
  logic        rd_sel;

  always_comb begin
    rd_sel = 1'b0;
    for (int i = 0; i < N_SECT; i++) begin
      if (rd_sector_i == SECT_W'(i)) rd_sel = mask_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_run_q <= '0;
    else if (st_i == ST_PWIN) win_run_q <= win_run_q + 1;
    else win_run_q <= '0;
  end

  a_r2_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !rb_low_o);
  a_r3_bit6_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_i == ST_PROG) |=> (rd_stat_o[6] != $past(rd_stat_o[6])));
  a_r3_other_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_o & 8'hBB) == 8'h00);
  a_r4_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ($stable(rd_stat_o) && $stable(rd_stat_vld_o)));
  a_r5_susp_bit6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_i == ST_ESUSP) |=> $stable(rd_stat_o[6]));
  a_r6_sprog_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SPROG && alg_done_i) |=> (!rb_low_o && st_i == ST_ESUSP));
  a_r7_bit2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rd_sel) |=> $stable(rd_stat_o[2]));
  a_r8_win_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_run_q <= WIN_CYC);
  a_r10_prog_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PROG && !alg_done_i) |=> (st_i == ST_PROG));
endmodule

bind flash_status_gen flash_status_chk #(
  .N_SECT(N_SECT), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alg_done_i    (alg_done_i),
  .rd_i          (rd_i),
  .rd_sector_i   (rd_sector_i),
  .rb_low_o      (rb_low_o),
  .rd_stat_o     (rd_stat_o),
  .rd_stat_vld_o (rd_stat_vld_o),
  .st_i          (st_q),
  .mask_i        (erase_mask)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N_SECT = 8;
  localparam int WIN_CYC = 50 * 2000 / 1000;

  logic       clk = 0, rst_ni = 0;
  logic       op_start = 0, op_erase = 0, alg_done = 0, suspend = 0, rd = 0;
  logic [2:0] op_sector = 0, rd_sector = 0;
  logic [7:0] erase_sel = 0, protect = 0;
  logic       rb_low, rd_vld;
  logic [7:0] rd_stat;
  int checks = 0, errors = 0;
  logic e6 = 0, e2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen i_flash_status_gen (
    .clk_i(clk), .rst_ni(rst_ni), .op_start_i(op_start), .op_erase_i(op_erase),
    .op_sector_i(op_sector), .alg_done_i(alg_done), .suspend_i(suspend),
    .erase_sel_i(erase_sel), .protect_i(protect), .rd_i(rd), .rd_sector_i(rd_sector),
    .rb_low_o(rb_low), .rd_stat_o(rd_stat), .rd_stat_vld_o(rd_vld)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_op(logic erase, logic [2:0] sec);
    @(negedge clk); op_start = 1; op_erase = erase; op_sector = sec;
    @(negedge clk); op_start = 0;
  endtask

  task automatic done_op();
    @(negedge clk); alg_done = 1;
    @(negedge clk); alg_done = 0;
  endtask

  task automatic do_read(string tag, logic [2:0] sec, logic f6, logic f2, logic vld);
    @(negedge clk); rd = 1; rd_sector = sec;
    @(negedge clk); rd = 0;
    e6 = e6 ^ f6; e2 = e2 ^ f2;
    check({tag, " stat"}, rd_stat, {1'b0, e6, 3'b0, e2, 2'b0});
    check({tag, " vld"}, rd_vld, vld);
  endtask

  task automatic t_reset();
    check("R1 rb", rb_low, 0);
    check("R1 stat", rd_stat, 0);
    check("R1 vld", rd_vld, 0);
  endtask

  task automatic t_program();
    start_op(0, 3'd1);
    check("R2 prog busy", rb_low, 1);
    do_read("R3 r11 read a", 3'd3, 1, 0, 1);
    do_read("R3 read b", 3'd0, 1, 0, 1);
    start_op(1, 3'd0);  // R10: erase start ignored while programming
    do_read("R10 still program", 3'd0, 1, 0, 1);
    check("R10 busy", rb_low, 1);
    done_op();
    check("R2 idle ready", rb_low, 0);
    do_read("R4 after done", 3'd3, 0, 0, 0);
  endtask

  task automatic t_erase();
    erase_sel = 8'h06; protect = 8'h04;  // effective set = sector 1 (R9)
    start_op(1, 3'd0);
    check("R2 erase busy", rb_low, 1);
    do_read("R7 r3 erasing sel", 3'd1, 1, 1, 1);
    do_read("R9 protected sel", 3'd2, 1, 0, 1);
    do_read("R7 unsel", 3'd5, 1, 0, 1);
    @(negedge clk); suspend = 1;
    @(negedge clk);
    check("R5 susp ready", rb_low, 0);
    do_read("R5 r7 susp sel", 3'd1, 0, 1, 1);
    do_read("R11 susp unsel", 3'd5, 0, 0, 0);
    start_op(1, 3'd3);  // R10: erase in suspend ignored
    check("R10 susp erase", rb_low, 0);
    start_op(0, 3'd6);
    check("R6 sprog busy", rb_low, 1);
    do_read("R6 sprog read", 3'd6, 1, 0, 1);
    done_op();
    check("R6 back to susp", rb_low, 0);
    do_read("R6 susp again", 3'd1, 0, 1, 1);
    @(negedge clk); suspend = 0;
    @(negedge clk);
    check("R5 resume busy", rb_low, 1);
    do_read("R5 resume toggles", 3'd4, 1, 0, 1);
    done_op();
    check("R2 erase done", rb_low, 0);
    do_read("R4 r7 after erase", 3'd1, 0, 0, 0);
    erase_sel = 0; protect = 0;
  endtask

  task automatic t_prot_prog();
    int n = 0;
    protect = 8'h08;
    start_op(0, 3'd3);
    while (rb_low && n < 4 * WIN_CYC) begin n++; @(negedge clk); end
    check("R8 window length", n, WIN_CYC);
    start_op(0, 3'd3);
    do_read("R8 win read a", 3'd0, 1, 0, 1);
    do_read("R8 win read b", 3'd7, 1, 0, 1);
    repeat (WIN_CYC) @(negedge clk);
    check("R8 back to idle", rb_low, 0);
    do_read("R8 idle read", 3'd0, 0, 0, 0);
    protect = 0;
  endtask

  task automatic t_prot_erase();
    int n = 0;
    erase_sel = 8'h30; protect = 8'h30;
    start_op(1, 3'd0);
    check("R9 all prot busy", rb_low, 1);
    do_read("R9 all prot toggle", 3'd4, 1, 0, 1);
    while (rb_low && n < 4 * WIN_CYC) begin n++; @(negedge clk); end
    check("R9 window length", n + 2, WIN_CYC);
    do_read("R9 back to array", 3'd4, 0, 0, 0);
    erase_sel = 0; protect = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_prot_prog();
    t_prot_erase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule